// File: doc/BRIEF.md
# Programmable Polynomial CRC Engine

This block computes a cyclic redundancy check over a byte stream. The generator polynomial is chosen at run time. A 5-bit order field selects a polynomial order from 1 to 32. A 32-bit tap vector switches on the intermediate feedback XOR stages. The top term x^n and the constant term x^0 are always part of the polynomial, whatever the tap vector holds.

The host first pulses `init_i`, which loads a starting remainder and captures the order and taps. It then offers bytes over a valid/ready handshake. Each accepted byte goes through a linear feedback shift register one bit per clock, most significant bit first. The remainder can be read on `crc_o` at any time. It is valid once `busy_o` falls after the last byte.

Top module: `crc_prog_engine`

## Requirements
- R1: The polynomial order is n = `order_i` + 1, from 1 to 32. Remainder bits at positions n and above always read as zero on `crc_o`. For n = 1 the remainder is the running parity of all data bits, XORed with the seed.
- R2: On each shift the feedback bit f is the data bit XOR remainder bit n-1. Stage 0 takes f. Each stage k from 1 to n-1 takes stage k-1, XORed with f when tap bit k is set. With all taps clear the register is a plain shift: n = 8, seed 0, byte 0x80 gives 0x80.
- R3: Tap bit 0 has no effect, because the constant term is always applied.
- R4: Tap bits at positions n and above have no effect, because x^n is implied by the order alone.
- R5: Data bits enter most significant bit first. With order 15, taps 0x1020, seed 0xFFFF and the ASCII string "123456789", the result is 0x29B1.
- R6: With order 31, taps 0x04C11DB6, seed 0xFFFFFFFF and the same string, the result is 0x0376E6E7.
- R7: A byte is accepted on a clock edge where `byte_valid_i` and `byte_ready_o` are both high and `init_i` is low. After acceptance, `byte_ready_o` is low and `busy_o` high for exactly 8 cycles. One bit is shifted per cycle.
- R8: A cycle with `init_i` high loads `seed_i`, masked to n bits using the `order_i` of that cycle. It aborts any shift in progress. It takes priority over a byte offered in the same cycle, and that byte is dropped. `crc_o` shows the masked seed one cycle later.
- R9: The order and taps are captured only on init or on byte acceptance. Changes to `order_i` or `taps_i` while a byte is shifting do not affect the result.
- R10: After reset, `crc_o` is 0, `byte_ready_o` is 1 and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load seed, capture config, abort shift |
| seed_i | input | 32 | Starting remainder |
| order_i | input | 5 | Polynomial order minus one |
| taps_i | input | 32 | Feedback stage enables, bit k for stage k |
| byte_valid_i | input | 1 | Data byte offered |
| byte_i | input | 8 | Data byte |
| byte_ready_o | output | 1 | Engine can accept a byte |
| busy_o | output | 1 | Byte being shifted |
| crc_o | output | 32 | Current remainder, zero-extended from n bits |

## Verification
The bench uses the default parameters: a 32-bit maximum order and 8-bit data. These settings make every order from 1 to 32 reachable, including the two edge orders where the mask logic runs out of room: the parity case at n = 1 and the full-width case with no spare bit above it. A behavioural reference checks each byte for random orders, taps and seeds. Directed cases cover the two fixed check strings, stray tap bits at position 0 and at or above n, an abort in the middle of a shift, and a collision between init and a byte offer.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_MAX_W  = 32;
  localparam int CRC_BYTE_W = 8;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/crc_cfg_hold.sv
module crc_cfg_hold #(
  parameter int MAX_W = crc_pkg::CRC_MAX_W,
  parameter int LEN_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [LEN_W-1:0] order_i,
  input  logic [MAX_W-1:0] taps_i,
  output logic [LEN_W-1:0] order_q_o,
  output logic [MAX_W-1:0] order_mask_o,
  output logic [MAX_W-1:0] tap_eff_o,
  output logic [MAX_W-1:0] load_mask_o
);
  logic [LEN_W-1:0] order_q, order_d;
  logic [MAX_W-1:0] taps_q, taps_d;

  always_comb begin
    order_d = order_q;
    taps_d  = taps_q;
    if (capture_i) begin
      order_d = order_i;
      taps_d  = taps_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= '0;
      taps_q  <= '0;
    end else if (capture_i) begin
      order_q <= order_d;
      taps_q  <= taps_d;
    end
  end

  // Per-stage masks: stage k exists when k <= order (n-1)
  for (genvar k = 0; k < MAX_W; k++) begin : g_stage
    assign order_mask_o[k] = (LEN_W'(k) <= order_q);
    assign load_mask_o[k]  = (LEN_W'(k) <= order_i);
    if (k == 0) begin : g_const
      assign tap_eff_o[k] = 1'b1;
    end else begin : g_tap
      assign tap_eff_o[k] = taps_q[k] & (LEN_W'(k) <= order_q);
    end
  end

  assign order_q_o = order_q;

  // R9: configuration only moves on a capture
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> ($stable(order_q) && $stable(taps_q)));
endmodule

// File: rtl/crc_byte_seq.sv
module crc_byte_seq #(
  parameter int BYTE_W = crc_pkg::CRC_BYTE_W,
  parameter int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              abort_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              shift_en_o,
  output logic              data_bit_o
);
  import crc_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              sr_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    sr_en   = 1'b0;
    if (abort_i) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept_i) begin
            state_d = SEQ_SHIFT;
            cnt_d   = '0;
            sr_d    = byte_i;
            sr_en   = 1'b1;
          end
        end
        SEQ_SHIFT: begin
          sr_d  = {sr_q[BYTE_W-2:0], 1'b0};
          sr_en = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign busy_o     = (state_q == SEQ_SHIFT);
  assign shift_en_o = (state_q == SEQ_SHIFT) && !abort_i;
  assign data_bit_o = sr_q[BYTE_W-1];

  // R7: acceptance starts a shift run
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !abort_i) |=> busy_o);
  // R7: the run advances one bit per clock
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !abort_i && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
  // R7: the run ends after the last bit
  a_r7_run_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !abort_i && cnt_q == LAST) |=> !busy_o);
  // R8: abort returns to idle
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o);
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core #(
  parameter int MAX_W = crc_pkg::CRC_MAX_W,
  parameter int LEN_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [MAX_W-1:0] load_val_i,
  input  logic             shift_en_i,
  input  logic             data_bit_i,
  input  logic [LEN_W-1:0] order_q_i,
  input  logic [MAX_W-1:0] order_mask_i,
  input  logic [MAX_W-1:0] tap_eff_i,
  output logic [MAX_W-1:0] rem_o
);
  logic [MAX_W-1:0] rem_q, rem_d, shifted;
  logic             fb;
  logic             rem_en;

  assign fb = data_bit_i ^ rem_q[order_q_i];

  for (genvar k = 0; k < MAX_W; k++) begin : g_shift
    if (k == 0) begin : g_lsb
      assign shifted[k] = fb & tap_eff_i[k];
    end else begin : g_upper
      assign shifted[k] = rem_q[k-1] ^ (fb & tap_eff_i[k]);
    end
  end

  always_comb begin
    rem_d  = rem_q;
    rem_en = 1'b0;
    if (load_i) begin
      rem_d  = load_val_i;
      rem_en = 1'b1;
    end else if (shift_en_i) begin
      rem_d  = shifted & order_mask_i;
      rem_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign rem_o = rem_q;

  // R2: stage 0 receives the feedback bit on each shift
  a_r2_stage0_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && !load_i) |=> (rem_q[0] == $past(fb)));
  // R1: after a shift no bit at or above the order survives
  a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && !load_i) |=> ((rem_q & ~$past(order_mask_i)) == '0));
  // R9: remainder holds when neither loading nor shifting
  a_r9_rem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en_i && !load_i) |=> $stable(rem_q));
endmodule

// File: rtl/crc_prog_engine.sv
module crc_prog_engine #(
  parameter int MAX_W  = crc_pkg::CRC_MAX_W,
  parameter int BYTE_W = crc_pkg::CRC_BYTE_W,
  localparam int LEN_W = $clog2(MAX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [MAX_W-1:0]  seed_i,
  input  logic [LEN_W-1:0]  order_i,
  input  logic [MAX_W-1:0]  taps_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              byte_ready_o,
  output logic              busy_o,
  output logic [MAX_W-1:0]  crc_o
);
  logic             busy;
  logic             accept;
  logic             shift_en;
  logic             data_bit;
  logic [LEN_W-1:0] order_q;
  logic [MAX_W-1:0] order_mask, tap_eff, load_mask;

  assign accept = byte_valid_i && !busy && !init_i;

  crc_cfg_hold #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_i    (init_i | accept),
    .order_i      (order_i),
    .taps_i       (taps_i),
    .order_q_o    (order_q),
    .order_mask_o (order_mask),
    .tap_eff_o    (tap_eff),
    .load_mask_o  (load_mask)
  );

  crc_byte_seq #(.BYTE_W(BYTE_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .abort_i    (init_i),
    .byte_i     (byte_i),
    .busy_o     (busy),
    .shift_en_o (shift_en),
    .data_bit_o (data_bit)
  );

  crc_lfsr_core #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (init_i),
    .load_val_i   (seed_i & load_mask),
    .shift_en_i   (shift_en),
    .data_bit_i   (data_bit),
    .order_q_i    (order_q),
    .order_mask_i (order_mask),
    .tap_eff_i    (tap_eff),
    .rem_o        (crc_o)
  );

  assign busy_o       = busy;
  assign byte_ready_o = !busy;

  // R8: init shows the masked seed one cycle later
  a_r8_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (crc_o == ($past(seed_i) & $past(load_mask)) && !busy_o));
  // R7: ready and busy are complementary
  a_r7_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o != busy_o);
  // R1: output never carries bits above the captured order
  a_r1_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !init_i) |=> ((crc_o & ~order_mask) == '0));
endmodule

// File: tb/test_crc_prog_engine.sv
module test_crc_prog_engine;
  logic        clk;
  logic        rst_n;
  logic        init_i;
  logic [31:0] seed_i;
  logic [4:0]  order_i;
  logic [31:0] taps_i;
  logic        byte_valid_i;
  logic [7:0]  byte_i;
  logic        byte_ready_o;
  logic        busy_o;
  logic [31:0] crc_o;

  int          n_tests;
  int          n_fail;
  logic [31:0] sb_q[$];
  logic [31:0] model;
  int          m_n;
  logic [31:0] m_tap;
  string       cur_tag;
  logic        busy_prev;
  logic        done;

  crc_prog_engine i_crc_prog_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_i       (init_i),
    .seed_i       (seed_i),
    .order_i      (order_i),
    .taps_i       (taps_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .byte_ready_o (byte_ready_o),
    .busy_o       (busy_o),
    .crc_o        (crc_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] nmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // Reference: constant term always present, taps limited below n
  function automatic logic [31:0] ref_byte(logic [31:0] r, logic [7:0] d, int n, logic [31:0] taps);
    logic [31:0] poly;
    logic        f;
    poly = (taps | 32'd1) & nmask(n);
    for (int i = 7; i >= 0; i--) begin
      f = d[i] ^ r[n-1];
      r = (r << 1) & nmask(n);
      if (f) r = r ^ poly;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compare when a shift run ends
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_prev && !busy_o && sb_q.size() > 0) begin
        check(cur_tag, crc_o, sb_q.pop_front());
      end
      busy_prev = busy_o;
    end else begin
      busy_prev = 1'b0;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy_o || sb_q.size() != 0);
    @(negedge clk);
  endtask

  task automatic do_init(logic [31:0] seed, logic [4:0] ord, logic [31:0] tap);
    wait_idle();
    init_i  = 1'b1;
    seed_i  = seed;
    order_i = ord;
    taps_i  = tap;
    m_n     = int'(ord) + 1;
    m_tap   = tap;
    model   = seed & nmask(m_n);
    @(negedge clk);
    init_i = 1'b0;
    check("R8 seed load", crc_o, model);
  endtask

  task automatic send_byte(logic [7:0] b, bit track);
    while (!byte_ready_o) @(negedge clk);
    byte_valid_i = 1'b1;
    byte_i       = b;
    if (track) begin
      model = ref_byte(model, b, m_n, m_tap);
      sb_q.push_back(model);
    end
    @(negedge clk);
    byte_valid_i = 1'b0;
  endtask

  task automatic send_check_string();
    string s;
    s = "123456789";
    for (int i = 0; i < s.len(); i++) send_byte(s[i], 1'b1);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int lowc;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; init_i = 1'b0; seed_i = '0; order_i = '0; taps_i = '0;
    byte_valid_i = 1'b0; byte_i = '0; busy_prev = 1'b0;
    m_n = 1; m_tap = '0; model = '0; cur_tag = "R2 stream";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 crc", crc_o, 32'h0);
    check("R10 ready", {31'd0, byte_ready_o}, 32'd1);
    check("R10 busy", {31'd0, busy_o}, 32'd0);

    // R5: 16-bit check string
    cur_tag = "R5 crc16 byte";
    do_init(32'h0000_FFFF, 5'd15, 32'h0000_1020);
    send_check_string();
    check("R5 crc16 check value", crc_o, 32'h0000_29B1);

    // R3: tap bit 0 ignored
    cur_tag = "R3 bit0 byte";
    do_init(32'h0000_FFFF, 5'd15, 32'h0000_1021);
    send_check_string();
    check("R3 bit0 ignored", crc_o, 32'h0000_29B1);

    // R4: taps at and above n ignored
    cur_tag = "R4 high taps byte";
    do_init(32'hFFFF_FFFF, 5'd15, 32'hFFFF_1020);
    send_check_string();
    check("R4 high taps ignored", crc_o, 32'h0000_29B1);

    // R6: 32-bit check string
    cur_tag = "R6 crc32 byte";
    do_init(32'hFFFF_FFFF, 5'd31, 32'h04C1_1DB6);
    send_check_string();
    check("R6 crc32 check value", crc_o, 32'h0376_E6E7);

    // R1: order 1 gives parity
    cur_tag = "R1 parity byte";
    do_init(32'h0, 5'd0, 32'hFFFF_FFFF);
    send_byte(8'hB3, 1'b1);
    wait_idle();
    check("R1 order1 parity", crc_o, 32'h1);

    // R2: plain shift with no taps
    cur_tag = "R2 plain byte";
    do_init(32'h0, 5'd7, 32'h0);
    send_byte(8'h80, 1'b1);
    wait_idle();
    check("R2 plain shift", crc_o, 32'h80);

    // R7: ready low for exactly eight cycles
    cur_tag = "R7 byte";
    do_init(32'h0000_FFFF, 5'd15, 32'h0000_1020);
    send_byte(8'h5A, 1'b1);
    lowc = 0;
    while (!byte_ready_o && lowc < 20) begin
      lowc++;
      @(negedge clk);
    end
    check("R7 ready low cycles", lowc, 32'd8);
    wait_idle();

    // R9: config changes while busy have no effect
    cur_tag = "R9 cfg while busy";
    do_init(32'h0000_FFFF, 5'd15, 32'h0000_1020);
    send_byte(8'h31, 1'b1);
    order_i = 5'd31;
    taps_i  = 32'h04C1_1DB6;
    wait_idle();
    order_i = 5'd15;
    taps_i  = 32'h0000_1020;

    // R8: init aborts a shift in progress
    do_init(32'h0000_FFFF, 5'd15, 32'h0000_1020);
    send_byte(8'h55, 1'b0);
    @(negedge clk); @(negedge clk);
    init_i = 1'b1; seed_i = 32'hABCD_1234; order_i = 5'd15;
    @(negedge clk);
    init_i = 1'b0;
    check("R8 abort seed", crc_o, 32'h0000_1234);
    check("R8 abort idle", {31'd0, busy_o}, 32'd0);
    @(negedge clk); @(negedge clk);
    check("R8 abort holds", crc_o, 32'h0000_1234);

    // R8: init wins over a byte in the same cycle
    init_i = 1'b1; seed_i = 32'h0000_BEEF; byte_valid_i = 1'b1; byte_i = 8'hAA;
    @(negedge clk);
    init_i = 1'b0; byte_valid_i = 1'b0;
    check("R8 collision busy", {31'd0, busy_o}, 32'd0);
    repeat (10) @(negedge clk);
    check("R8 collision byte dropped", crc_o, 32'h0000_BEEF);

    // Random orders, taps, seeds and streams against the reference
    cur_tag = "R2 random stream";
    for (int t = 0; t < 60; t++) begin
      logic [4:0] ord;
      int nb;
      ord = 5'($urandom_range(0, 31));
      do_init($urandom, ord, $urandom);
      nb = $urandom_range(1, 6);
      for (int b = 0; b < nb; b++) send_byte(8'($urandom), 1'b1);
      wait_idle();
      check("R1 random zero-extend", crc_o & ~nmask(int'(ord) + 1), 32'h0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule